// File: doc/BRIEF.md
# Two-Tier Prioritised Bus Arbiter

This block is the central arbiter of a shared bus. Its potential masters sit in a small number of priority groups called levels. Each master belongs to exactly one level. The masters of a level share one request line, which is the OR of their individual requests, and one level grant line.

Arbitration happens in two tiers. First the controller picks the requesting level with the highest priority, and level 0 ranks highest. Then it drives that level's grant into a daisy chain of that level's masters. The chain runs in ascending master index, so the nearest master sees the grant first. A master that sees the grant and is requesting claims the bus and blocks the grant. A master that is not requesting passes the grant to the next member of its level. If the grant runs off the end of the chain with no taker, it is withdrawn and the requests are looked at again.

The controller has three states:
- `ST_IDLE`: the bus is free.
- `ST_OFFER`: a level grant is driven for one cycle.
- `ST_HELD`: the bus is owned, and the busy line is high.

It has five transitions:
- `IDLE->OFFER`: some level is requesting.
- `IDLE->IDLE`: no level is requesting.
- `OFFER->HELD`: a master claimed the grant.
- `OFFER->IDLE`: the grant was unclaimed and is withdrawn.
- `HELD->IDLE`: the owner pulses done.

`HELD->HELD` holds the bus until that pulse arrives.

Top module: `bus_level_arbiter`

## Requirements
- R1: While reset is low and right after it, `bus_busy` is 0, `lvl_grant` and both chain vectors are all zero, and `owner_idx` is 0.
- R2: Master i belongs to the level held in field i of `LEVEL_MAP`. By default masters 0 and 2 are on level 0 and masters 1 and 3 are on level 1. When several levels request in `ST_IDLE`, the lowest-numbered level is chosen.
- R3: A request seen in `ST_IDLE` raises exactly one bit of `lvl_grant` on the next cycle, and only for the chosen level. `lvl_grant` stays high for that single cycle (`ST_OFFER`).
- R4: The level grant enters the lowest-index master of that level's chain. Masters of other levels see `grant_in` low.
- R5: A master whose `grant_in` is high while its own `req` bit is high drives `grant_out` low and claims the bus. A master with `req` low drives `grant_out` equal to `grant_in`, and that value is the `grant_in` of the next member of its level.
- R6: The cycle after a claim, `bus_busy` is 1 and `owner_idx` holds the index of the claiming master.
- R7: `bus_busy` and `owner_idx` stay unchanged until a cycle in which `xfer_done` is 1. In the cycle after that, `bus_busy` is 0.
- R8: While `bus_busy` is 1, `lvl_grant` and `grant_in` are all zero, whatever the requests are.
- R9: If no master of the offered level claims the grant, the next cycle has `bus_busy` 0 and no level grant. Arbitration then restarts from the requests present in that cycle.
- R10: `xfer_done` has no effect while the bus is not held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | NUM_MASTERS | Per-master bus request |
| xfer_done | input | 1 | One-cycle end-of-transaction pulse from the owner |
| grant_in | output | NUM_MASTERS | Grant arriving at each master |
| grant_out | output | NUM_MASTERS | Grant passed on by each master |
| lvl_grant | output | NUM_LEVELS | Grant line of each level |
| bus_busy | output | 1 | Bus in use |
| owner_idx | output | $clog2(NUM_MASTERS) | Index of the current owner |

## Verification
The embedded properties watch several rules on every cycle:
- at most one level grant is high at a time;
- at most one master claims a grant;
- no grant is driven during busy;
- a claim turns busy on in the next cycle;
- busy and the owner are held until done;
- an unclaimed offer is withdrawn.

The bench scenarios are what show that the right level and the right master win. They sweep every request pattern of the default four-master, two-level setup and compare the chain vectors with values computed in the bench. They also show that new requests are re-arbitrated after a withdrawal, and that done is ignored outside `ST_HELD`.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_HELD  = 2'd2
    } arb_state_e;
endpackage

// File: rtl/arb_level_select.sv
module arb_level_select #(
    parameter int NUM_MASTERS = 4,
    parameter int NUM_LEVELS  = 2,
    parameter int LVL_W       = 1,
    parameter logic [NUM_MASTERS*LVL_W-1:0] LEVEL_MAP = '0
) (
    input  logic [NUM_MASTERS-1:0] req,
    output logic [NUM_LEVELS-1:0]  level_req,
    output logic                   pick_valid,
    output logic [LVL_W-1:0]       pick_level
);
    // Shared level request: OR of the members of each level
    always_comb begin
        level_req = '0;
        for (int i = 0; i < NUM_MASTERS; i++) begin
            if (req[i]) begin
                level_req[LEVEL_MAP[i*LVL_W +: LVL_W]] = 1'b1;
            end
        end
    end

    // Level 0 has the highest priority
    always_comb begin
        pick_valid = |level_req;
        pick_level = '0;
        for (int l = NUM_LEVELS - 1; l >= 0; l--) begin
            if (level_req[l]) begin
                pick_level = LVL_W'(l);
            end
        end
    end
endmodule

// File: rtl/arb_chain.sv
module arb_chain #(
    parameter int NUM_MASTERS = 4,
    parameter int NUM_LEVELS  = 2,
    parameter int LVL_W       = 1,
    parameter logic [NUM_MASTERS*LVL_W-1:0] LEVEL_MAP = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LEVELS-1:0]  lvl_grant,
    input  logic [NUM_MASTERS-1:0] req,
    output logic [NUM_MASTERS-1:0] grant_in,
    output logic [NUM_MASTERS-1:0] grant_out,
    output logic [NUM_MASTERS-1:0] taken
);
    logic [NUM_LEVELS-1:0] carry;
    logic [LVL_W-1:0]      lv;

    // Walk the masters in ascending index; each level keeps its own carry
    always_comb begin
        carry = lvl_grant;
        lv    = '0;
        for (int i = 0; i < NUM_MASTERS; i++) begin
            lv           = LEVEL_MAP[i*LVL_W +: LVL_W];
            grant_in[i]  = carry[lv];
            grant_out[i] = carry[lv] & ~req[i];
            taken[i]     = carry[lv] & req[i];
            carry[lv]    = carry[lv] & ~req[i];
        end
    end

    assert_single_taker_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(taken));
    assert_taker_requested_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (taken & ~req) == '0);
    assert_no_stray_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_grant == '0) |-> (grant_in == '0));
endmodule

// File: rtl/bus_level_arbiter.sv
module bus_level_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    parameter int NUM_LEVELS  = 2,
    parameter int LVL_W       = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1,
    parameter logic [NUM_MASTERS*LVL_W-1:0] LEVEL_MAP = 4'b1010
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req,
    input  logic                   xfer_done,
    output logic [NUM_MASTERS-1:0] grant_in,
    output logic [NUM_MASTERS-1:0] grant_out,
    output logic [NUM_LEVELS-1:0]  lvl_grant,
    output logic                   bus_busy,
    output logic [((NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1)-1:0] owner_idx
);
    localparam int OWN_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;

    arb_state_e             state_q, state_d;
    logic [LVL_W-1:0]       sel_q;
    logic [OWN_W-1:0]       own_q;
    logic [OWN_W-1:0]       taker_idx;
    logic [NUM_LEVELS-1:0]  level_req;
    logic                   pick_valid;
    logic [LVL_W-1:0]       pick_level;
    logic [NUM_MASTERS-1:0] taken;

    arb_level_select #(
        .NUM_MASTERS(NUM_MASTERS), .NUM_LEVELS(NUM_LEVELS),
        .LVL_W(LVL_W), .LEVEL_MAP(LEVEL_MAP)
    ) u_select (
        .req(req), .level_req(level_req),
        .pick_valid(pick_valid), .pick_level(pick_level)
    );

    arb_chain #(
        .NUM_MASTERS(NUM_MASTERS), .NUM_LEVELS(NUM_LEVELS),
        .LVL_W(LVL_W), .LEVEL_MAP(LEVEL_MAP)
    ) u_chain (
        .clk(clk), .rst_n(rst_n), .lvl_grant(lvl_grant), .req(req),
        .grant_in(grant_in), .grant_out(grant_out), .taken(taken)
    );

    // Index of the claiming master (at most one bit of taken is set)
    always_comb begin
        taker_idx = '0;
        for (int i = 0; i < NUM_MASTERS; i++) begin
            if (taken[i]) taker_idx = OWN_W'(i);
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (pick_valid) state_d = ST_OFFER;
            ST_OFFER: state_d = (|taken) ? ST_HELD : ST_IDLE;
            ST_HELD:  if (xfer_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and captured level and owner
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
            own_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && pick_valid) sel_q <= pick_level;
            if (state_q == ST_OFFER && |taken)    own_q <= taker_idx;
        end
    end

    // Outputs
    always_comb begin
        lvl_grant = '0;
        bus_busy  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_OFFER: lvl_grant[sel_q] = 1'b1;
            ST_HELD:  bus_busy = 1'b1;
            default:  ;
        endcase
        owner_idx = own_q;
    end

    assert_one_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lvl_grant));
    assert_offer_follows_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_busy && lvl_grant == '0 && |req) |=> $onehot(lvl_grant));
    assert_offer_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_grant != '0) |=> (lvl_grant == '0));
    assert_no_grant_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy |-> (lvl_grant == '0 && grant_in == '0));
    assert_claim_sets_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(grant_in & req)) |=> bus_busy);
    assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy && !xfer_done) |=> (bus_busy && $stable(owner_idx)));
    assert_done_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy && xfer_done) |=> !bus_busy);
    assert_unclaimed_withdrawn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_grant != '0 && (grant_in & req) == '0) |=> (!bus_busy && lvl_grant == '0));
    assert_done_ignored_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_busy && lvl_grant == '0) |=> !bus_busy);
endmodule

// File: tb/tb_bus_level_arbiter.sv
module tb_bus_level_arbiter;
    localparam int NM = 4;
    localparam int NL = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NM-1:0] req = '0;
    logic          xfer_done = 1'b0;
    logic [NM-1:0] grant_in, grant_out;
    logic [NL-1:0] lvl_grant;
    logic          bus_busy;
    logic [1:0]    owner_idx;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bus_level_arbiter dut (
        .clk(clk), .rst_n(rst_n), .req(req), .xfer_done(xfer_done),
        .grant_in(grant_in), .grant_out(grant_out), .lvl_grant(lvl_grant),
        .bus_busy(bus_busy), .owner_idx(owner_idx)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Default map (R2): level of master i is i % 2
    function automatic int sel_level(input logic [NM-1:0] r);
        return (r[0] | r[2]) ? 0 : 1;
    endfunction

    function automatic logic [NM-1:0] exp_gin(input logic [NM-1:0] r, input int lvl);
        logic [NM-1:0] g;
        g = '0;
        for (int i = 0; i < NM; i++) begin
            if (i % 2 == lvl) begin
                g[i] = 1'b1;
                for (int j = 0; j < i; j++)
                    if (j % 2 == lvl && r[j]) g[i] = 1'b0;
            end
        end
        return g;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        #2;
        check("R1 reset busy", int'(bus_busy), 0);
        check("R1 reset lvl_grant", int'(lvl_grant), 0);
        check("R1 reset grant_in", int'(grant_in), 0);
        check("R1 reset owner", int'(owner_idx), 0);
        tick(); tick();
        rst_n = 1'b1;
        tick(); #1;
        check("R1 after reset busy", int'(bus_busy), 0);
        check("R1 after reset grant_out", int'(grant_out), 0);

        // R10: done while idle does nothing
        xfer_done = 1'b1;
        tick(); xfer_done = 1'b0; #1;
        check("R10 busy", int'(bus_busy), 0);
        check("R10 lvl_grant", int'(lvl_grant), 0);

        // Exhaustive sweep of request patterns (R2..R8)
        for (int p = 1; p < 16; p++) begin
            logic [NM-1:0] r, gi;
            int sl, win;
            r  = NM'(p);
            sl = sel_level(r);
            gi = exp_gin(r, sl);
            win = 0;
            for (int i = NM - 1; i >= 0; i--)
                if (gi[i] && r[i]) win = i;
            tick(); req = r; #1;
            check("R3 no grant in idle", int'(lvl_grant), 0);
            tick(); #1;
            check("R2 R3 level grant", int'(lvl_grant), 1 << sl);
            check("R4 R5 grant_in", int'(grant_in), int'(gi));
            check("R5 grant_out", int'(grant_out), int'(gi & ~r));
            tick(); req = ~r; #1;
            check("R6 busy", int'(bus_busy), 1);
            check("R6 owner", int'(owner_idx), win);
            check("R8 no lvl_grant when busy", int'(lvl_grant), 0);
            check("R8 no grant_in when busy", int'(grant_in), 0);
            tick(); req = '0; #1;
            check("R7 busy held", int'(bus_busy), 1);
            check("R7 owner held", int'(owner_idx), win);
            xfer_done = 1'b1;
            tick(); xfer_done = 1'b0; #1;
            check("R7 released", int'(bus_busy), 0);
        end

        // R9: withdrawal, then re-arbitration to level 1
        tick(); req = 4'b0001; #1;
        tick(); req = 4'b0010; #1;
        check("R9 offer level0", int'(lvl_grant), 1);
        check("R9 chain runs through", int'(grant_out), 4'b0101);
        tick(); #1;
        check("R9 withdrawn busy", int'(bus_busy), 0);
        check("R9 withdrawn grant", int'(lvl_grant), 0);
        tick(); #1;
        check("R9 reoffer level1", int'(lvl_grant), 2);
        check("R9 reoffer grant_in", int'(grant_in), 4'b0010);
        tick(); req = '0; #1;
        check("R9 new owner busy", int'(bus_busy), 1);
        check("R9 new owner idx", int'(owner_idx), 1);
        xfer_done = 1'b1;
        tick(); xfer_done = 1'b0; #1;
        check("R7 final release", int'(bus_busy), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        finished = 1'b1;
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule